// File: doc/BRIEF.md
# Cascaded Pacer Rate Divider

This block produces a periodic, active-low pacing strobe by dividing a reference timebase through two chained 16-bit rate generators, which gives a 32-bit overall divide ratio. The reference arrives as a single-cycle enable, `ref_en`, in the system clock domain. A 10 MHz reference, for example, is one enable per 100 ns. The lower stage counts reference ticks. Each time it finishes a cycle it hands one tick to the upper stage. The output of the upper stage is the internal pacer.

Software drives the block over an 8-bit write-only register port. A control write picks a stage and its operating mode. Two byte writes to that stage's data offset then deliver the 16-bit divisor, low byte first. A one-bit select register routes either the internal pacer or an external trigger input to the ADC pacing output.

Top module: `pacer_divider`

## Requirements
- R1: After reset, `internal_pacer` is 1, both stages are idle, and the source select is 0, so `adc_pacer` follows `ext_trig`.
- R2: The register offsets on `wr_addr` are as follows. 0 is the source select, in bit 0. 1 is the lower stage's divisor. 2 is the upper stage's divisor. 3 is the control byte. In the control byte, bits [7:6] pick the stage (01 = lower, 10 = upper) and bits [3:1] carry the mode. Bits [5:4] and bit 0 of the control byte have no effect.
- R3: A control write to a stage stops that stage, which drives its output high, and returns its byte pointer to the low byte.
- R4: A stage starts counting only after both bytes of its divisor have been written. It loads the divisor on the next tick at its input.
- R5: A divisor is written as two bytes at one offset: first the low byte, then the high byte.
- R6: A running stage with divisor N keeps its output high, except for exactly one input-tick period in every N ticks, when it drives the output low.
- R7: A divisor of 0 acts as 65536.
- R8: The upper stage is ticked only by the lower stage's terminal count. `internal_pacer` therefore has a period of N1×N2 reference ticks and stays low for N1 reference ticks.
- R9: A control write whose mode field is not 010 (rate generator) leaves the stage idle with its output high, even after a divisor is written.
- R10: A control write whose stage field is 00 or 11 changes nothing.
- R11: `adc_pacer` equals `internal_pacer` when the select bit is 1 and `ext_trig` when it is 0.
- R12: The stages advance only in cycles where `ref_en` is 1. With a tick every G clocks, every interval stretches by a factor of G.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | Reference tick enable, one cycle per reference period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register offset |
| wr_data | input | 8 | Register write data |
| ext_trig | input | 1 | External pacing trigger |
| internal_pacer | output | 1 | Active-low strobe of the upper stage |
| adc_pacer | output | 1 | Selected ADC pacing source |

## Verification
The hardest case to reach is the 65536 interpretation of a zero divisor. The bench can only observe it at `internal_pacer`, and a full zero-divisor pacer period is too long to measure. The bench therefore runs the pair with a long lower divisor and catches the pacer while it is low. It then reprograms the lower stage to zero. This freezes the upper stage in its low phase. The bench then counts the cycles until the pacer rises, which takes one complete 65536-tick lower cycle. The half-written divisor cases are reached in a similar way. The bench stalls after the low byte or reissues a control word in between, then watches whether the pacer stays high or runs at the rate of the correctly assembled divisor.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      OFS_SELECT   = 2'd0,
      OFS_LOW_CNT  = 2'd1,
      OFS_HIGH_CNT = 2'd2,
      OFS_CONTROL  = 2'd3
   } pacer_ofs_e;

   localparam logic [2:0] MODE_RATE_GEN = 3'b010;
   localparam int CTL_STAGE_LSB = 6;
   localparam int CTL_MODE_LSB  = 1;
endpackage

// File: rtl/pacer_regif.sv
module pacer_regif
   import pacer_pkg::*;
#(
   parameter int BUS_W  = 8,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BUS_W-1:0]  wr_data,
   output logic [STAGES-1:0] ctrl_wr,
   output logic [STAGES-1:0] data_wr,
   output logic              mode_ok,
   output logic [BUS_W-1:0]  lane_data,
   output logic              sel_q
);
   generate
      if (BUS_W < 8) begin : g_bus_chk
         $error("pacer_regif: control byte needs BUS_W >= 8");
      end
      if (STAGES != 2) begin : g_stage_chk
         $error("pacer_regif: register map covers exactly two stages");
      end
   endgenerate

   pacer_ofs_e ofs;
   logic [1:0] ctl_stage;

   assign ofs       = pacer_ofs_e'(wr_addr);
   assign ctl_stage = wr_data[CTL_STAGE_LSB +: 2];
   assign mode_ok   = (wr_data[CTL_MODE_LSB +: 3] == MODE_RATE_GEN);
   assign lane_data = wr_data;

   for (genvar i = 0; i < STAGES; i++) begin : g_dec
      assign ctrl_wr[i] = wr_en && (ofs == OFS_CONTROL) && (ctl_stage == 2'(i + 1));
      assign data_wr[i] = wr_en && (wr_addr == ADDR_W'(i + 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel_q <= 1'b0;
      else if (wr_en && ofs == OFS_SELECT)
         sel_q <= wr_data[0];
   end
endmodule

// File: rtl/pacer_rate_counter.sv
module pacer_rate_counter #(
   parameter int CNT_W = 16,
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_in,
   input  logic             ctrl_wr,
   input  logic             ctrl_mode_ok,
   input  logic             data_wr,
   input  logic [BUS_W-1:0] data_in,
   output logic             out_n,
   output logic             tick_out
);
   localparam int LANES = CNT_W / BUS_W;
   localparam int PTR_W = (LANES > 1) ? $clog2(LANES) : 1;
   localparam logic [PTR_W-1:0] LAST_LANE = PTR_W'(LANES - 1);
   localparam logic [CNT_W-1:0] TERM      = CNT_W'(1);

   generate
      if ((CNT_W % BUS_W) != 0 || LANES < 1) begin : g_width_chk
         $error("pacer_rate_counter: CNT_W must be a whole multiple of BUS_W");
      end
   endgenerate

   logic [CNT_W-1:0] stage_q, stage_nx, reload_q, count_q;
   logic [PTR_W-1:0] lane_q;
   logic             armed_q, pend_q, run_q, at_term;

   always_comb begin
      stage_nx = stage_q;
      stage_nx[lane_q*BUS_W +: BUS_W] = data_in;
   end

   assign at_term  = run_q && (count_q == TERM);
   assign out_n    = !at_term;
   assign tick_out = tick_in && at_term && !pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q  <= '0;
         reload_q <= '0;
         count_q  <= '0;
         lane_q   <= '0;
         armed_q  <= 1'b0;
         pend_q   <= 1'b0;
         run_q    <= 1'b0;
      end else if (ctrl_wr) begin
         armed_q <= ctrl_mode_ok;
         run_q   <= 1'b0;
         pend_q  <= 1'b0;
         lane_q  <= '0;
      end else begin
         if (tick_in) begin
            if (pend_q) begin
               count_q <= reload_q;
               run_q   <= 1'b1;
               pend_q  <= 1'b0;
            end else if (run_q) begin
               count_q <= at_term ? reload_q : count_q - TERM;
            end
         end
         if (data_wr) begin
            stage_q <= stage_nx;
            if (lane_q == LAST_LANE) begin
               lane_q   <= '0;
               reload_q <= stage_nx;
               pend_q   <= armed_q;
            end else begin
               lane_q <= lane_q + PTR_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/pacer_divider.sv
module pacer_divider
   import pacer_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int BUS_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BUS_W-1:0]  wr_data,
   input  logic              ext_trig,
   output logic              internal_pacer,
   output logic              adc_pacer
);
   localparam int STAGES = 2;

   logic [STAGES-1:0] ctrl_wr, data_wr, stage_out;
   logic [STAGES:0]   stage_tick;
   logic [BUS_W-1:0]  lane_data;
   logic              mode_ok, sel_q;

   pacer_regif #(.BUS_W(BUS_W), .STAGES(STAGES)) u_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .ctrl_wr   (ctrl_wr),
      .data_wr   (data_wr),
      .mode_ok   (mode_ok),
      .lane_data (lane_data),
      .sel_q     (sel_q)
   );

   assign stage_tick[0] = ref_en;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      pacer_rate_counter #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_cnt (
         .clk          (clk),
         .rst_n        (rst_n),
         .tick_in      (stage_tick[i]),
         .ctrl_wr      (ctrl_wr[i]),
         .ctrl_mode_ok (mode_ok),
         .data_wr      (data_wr[i]),
         .data_in      (lane_data),
         .out_n        (stage_out[i]),
         .tick_out     (stage_tick[i+1])
      );
   end

   assign internal_pacer = stage_out[STAGES-1];
   assign adc_pacer      = sel_q ? internal_pacer : ext_trig;
endmodule

// File: rtl/pacer_divider_chk.sv
module pacer_divider_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ref_en,
   input logic       wr_en,
   input logic [1:0] wr_addr,
   input logic [7:0] wr_data,
   input logic       lo_out,
   input logic       lo_tick,
   input logic       hi_tick,
   input logic       pacer,
   input logic       sel
);
   logic ctl_lower;
   assign ctl_lower = wr_en && (wr_addr == 2'd3) && (wr_data[7:6] == 2'b01);

   AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == 2'd0) |=> $stable(sel)); // R2
   AST_CTRL_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_lower |=> lo_out); // R3
   AST_BAD_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_lower && wr_data[3:1] != 3'b010) |=> lo_out ##1 lo_out); // R9
   AST_UPPER_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!lo_tick && !wr_en) |=> $stable(pacer)); // R8
   AST_NO_REF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ref_en && !wr_en) |=> ($stable(lo_out) && $stable(pacer))); // R12
   AST_TICK_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      hi_tick |-> !pacer); // R6
endmodule

bind pacer_divider pacer_divider_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ref_en  (ref_en),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .lo_out  (stage_out[0]),
   .lo_tick (stage_tick[1]),
   .hi_tick (stage_tick[2]),
   .pacer   (internal_pacer),
   .sel     (sel_q)
);

// File: tb/pacer_divider_test.sv
`timescale 1ns/1ps
module pacer_divider_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_en = 1'b1;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       ext_trig = 1'b0;
   logic       internal_pacer, adc_pacer;

   int n_checks = 0;
   int n_fail   = 0;
   int ref_gap  = 1;

   pacer_divider uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .ref_en         (ref_en),
      .wr_en          (wr_en),
      .wr_addr        (wr_addr),
      .wr_data        (wr_data),
      .ext_trig       (ext_trig),
      .internal_pacer (internal_pacer),
      .adc_pacer      (adc_pacer)
   );

   always #2.5 clk = ~clk;

   // rows: N1, N2, reference gap, expected period (clk), expected low width (clk)
   localparam int VEC [0:4][0:4] = '{
      '{2, 3, 1,  6,  2},
      '{3, 2, 1,  6,  3},
      '{5, 4, 1, 20,  5},
      '{2, 2, 2,  8,  4},
      '{4, 3, 3, 36, 12}
   };

   initial begin
      int phase = 0;
      forever begin
         @(negedge clk);
         ref_en = (phase == 0);
         phase  = (phase + 1 >= ref_gap) ? 0 : phase + 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] ctl(input logic [1:0] stage, input logic [2:0] mode);
      return {stage, 2'b11, mode, 1'b0};
   endfunction

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic count_level(input logic lvl, input int limit, output int n);
      n = 0;
      while (internal_pacer === lvl && n < limit) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic setup_pair(input int n1, input int n2);
      wr(2'd3, ctl(2'b01, 3'b010));
      wr(2'd3, ctl(2'b10, 3'b010));
      wr(2'd2, 8'(n2));
      wr(2'd2, 8'(n2 >> 8));
      wr(2'd1, 8'(n1));
      wr(2'd1, 8'(n1 >> 8));
   endtask

   task automatic measure(output int lw, output int period);
      int hw, skip;
      count_level(1'b0, 2000, skip);
      count_level(1'b1, 2000, skip);
      count_level(1'b0, 2000, lw);
      count_level(1'b1, 2000, hw);
      period = lw + hw;
   endtask

   task automatic hold_high(input int cycles, output int bad);
      bad = 0;
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         if (internal_pacer !== 1'b1) bad++;
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      int lw, per, bad, n;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(internal_pacer === 1'b1, "R1 pacer idle in reset", int'(internal_pacer), 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      ext_trig = 1'b1;
      @(negedge clk);
      check(adc_pacer === 1'b1, "R1 select defaults external", int'(adc_pacer), 1);
      ext_trig = 1'b0;
      @(negedge clk);
      check(adc_pacer === 1'b0 && internal_pacer === 1'b1, "R1 external low, pacer high",
            int'(adc_pacer), 0);

      // R2 R4 R5 R6 R8 R12: divide ratio table
      for (int v = 0; v < 5; v++) begin
         ref_gap = VEC[v][2];
         setup_pair(VEC[v][0], VEC[v][1]);
         measure(lw, per);
         check(per == VEC[v][3], "R8 R12 pacer period", per, VEC[v][3]);
         check(lw == VEC[v][4], "R6 R12 pacer low width", lw, VEC[v][4]);
      end
      ref_gap = 1;

      // R11: source select
      setup_pair(2, 3);
      wr(2'd0, 8'h01);
      bad = 0;
      for (int k = 0; k < 40; k++) begin
         ext_trig = k[0];
         @(negedge clk);
         if (adc_pacer !== internal_pacer) bad++;
      end
      check(bad == 0, "R11 select internal", bad, 0);
      wr(2'd0, 8'hFE);
      bad = 0;
      for (int k = 0; k < 40; k++) begin
         ext_trig = k[1];
         @(negedge clk);
         if (adc_pacer !== ext_trig) bad++;
      end
      check(bad == 0, "R11 select external", bad, 0);

      // R10: control writes naming stage 00 or 11 are ignored
      setup_pair(3, 2);
      wr(2'd3, ctl(2'b00, 3'b010));
      wr(2'd3, ctl(2'b11, 3'b010));
      measure(lw, per);
      check(per == 6 && lw == 3, "R10 ignored control keeps period", per, 6);

      // R3: a new control word returns the byte pointer to the low byte
      wr(2'd3, ctl(2'b01, 3'b010));
      wr(2'd3, ctl(2'b10, 3'b010));
      wr(2'd2, 8'd2);
      wr(2'd2, 8'd0);
      wr(2'd1, 8'd7);
      wr(2'd3, ctl(2'b01, 3'b010));
      wr(2'd1, 8'd3);
      wr(2'd1, 8'd0);
      measure(lw, per);
      check(per == 6 && lw == 3, "R3 pointer reset gives divisor 3", per, 6);

      // R4 R5: low byte alone does not start the stage
      wr(2'd3, ctl(2'b01, 3'b010));
      wr(2'd3, ctl(2'b10, 3'b010));
      wr(2'd2, 8'd3);
      wr(2'd2, 8'd0);
      wr(2'd3, ctl(2'b01, 3'b010));
      wr(2'd1, 8'd2);
      hold_high(200, bad);
      check(bad == 0, "R4 no count after low byte only", bad, 0);
      wr(2'd1, 8'd0);
      measure(lw, per);
      check(per == 6 && lw == 2, "R5 high byte completes divisor", per, 6);

      // R9: a mode other than rate generator leaves the stage idle
      wr(2'd3, ctl(2'b01, 3'b000));
      wr(2'd3, ctl(2'b10, 3'b010));
      wr(2'd2, 8'd2);
      wr(2'd2, 8'd0);
      wr(2'd1, 8'd2);
      wr(2'd1, 8'd0);
      hold_high(200, bad);
      check(bad == 0, "R9 bad mode stays idle", bad, 0);

      // R7: divisor 0 acts as 65536
      setup_pair(50, 2);
      count_level(1'b0, 500, n);
      count_level(1'b1, 500, n);
      wr(2'd3, ctl(2'b01, 3'b010));
      wr(2'd1, 8'd0);
      wr(2'd1, 8'd0);
      check(internal_pacer === 1'b0, "R3 stopped lower freezes pacer low", int'(internal_pacer), 0);
      count_level(1'b0, 70000, n);
      check(n >= 65536 && n <= 65540, "R7 zero divisor spans 65536 ticks", n, 65537);

      finish_run();
   end
endmodule